// File: doc/BRIEF.md
# Receive Remaining Byte Counter

This block counts down the unused part of a serial infrared receiver's buffer while a message comes in. When a message starts, the counter takes the programmed 12-bit receive size. Each byte the receiver accepts takes one off the count. When the message ends, the count is frozen so that software can read what is left through two byte-wide read ports. Software then finds the received length by subtracting that residual from the programmed size.

Because the counter holds bytes remaining, a residual of zero means the message filled the whole programmed size. The largest message is 2048 bytes (size 0x800). If more bytes arrive than were programmed, the count stops at zero and does not wrap, and an overflow flag is raised. Power-on reset and two synchronous clears, one for a master reset and one for an error reset, all bring the count back to zero.

Top module: `rx_remain_counter`

## Requirements
- R1: After the asynchronous reset `rst_ni`, the residual count is 0x000, `overflow_o` is low and the block is idle. Byte strobes do nothing until a start strobe arrives.
- R2: A `msg_start_i` pulse loads the residual count with `rx_size_i` and clears `overflow_o`. The new count is visible one cycle later.
- R3: During an open message, each `byte_strobe_i` pulse lowers the count by exactly one. In the idle state, byte strobes leave the count unchanged.
- R4: When a byte strobe arrives while the count is zero, the count stays at 0x000 and `overflow_o` goes high. The flag stays high until the next start strobe or clear.
- R5: A `msg_end_i` pulse freezes the count. Byte strobes after it are ignored until the next start strobe. A byte strobe in the same cycle as the end pulse is still counted.
- R6: A start strobe and a byte strobe in the same cycle give a count of `rx_size_i` minus one. If `rx_size_i` is zero, the count is 0x000 and the overflow flag is set.
- R7: Read offset 4 returns count bits [7:0]. Read offset 5 returns count bits [11:8] in bits [3:0], and bits [7:4] read as zero. Every other offset reads 0x00.
- R8: A `master_rst_i` or `error_rst_i` pulse clears the count and the overflow flag and returns the block to idle. It wins over any strobe in the same cycle.
- R9: With size 0x800 programmed and 2048 bytes received, the residual is 0x000 with no overflow. The length computed as size minus residual is therefore 2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| master_rst_i | input | 1 | Synchronous master clear |
| error_rst_i | input | 1 | Synchronous error clear |
| rx_size_i | input | 12 | Programmed receive size, loaded at message start |
| msg_start_i | input | 1 | Start-of-message strobe |
| byte_strobe_i | input | 1 | One received byte |
| msg_end_i | input | 1 | End-of-message strobe |
| reg_addr_i | input | 3 | Read offset |
| reg_rdata_o | output | 8 | Read data, combinational from the offset |
| overflow_o | output | 1 | More bytes arrived than the programmed size |

## Verification
Two pairs of events can land in the same cycle. A byte strobe can coincide with the end-of-message strobe, and a byte strobe can coincide with the start strobe. The bench drives each pair together on one edge. It then reads the residual through offsets 4 and 5: for byte plus end it expects one fewer than before, and for start plus byte it expects size minus one. For byte plus end, it also sends further byte strobes afterwards and checks that the frozen residual does not move. A clear asserted together with strobes is checked the same way, and the expected result is zero.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_HOLD  = 2'd2
  } rrc_state_e;
endpackage

// File: rtl/rrc_ctrl.sv
module rrc_ctrl
  import rrc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic start_i,
  input  logic byte_i,
  input  logic end_i,
  output logic load_o,
  output logic dec_o,
  output logic hold_o
);
  rrc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (clear_i)                                state_d = ST_IDLE;
    else if (start_i)                           state_d = ST_COUNT;
    else if (end_i && state_q == ST_COUNT)      state_d = ST_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // start opens the message in the same cycle, so a coincident byte counts
  assign load_o = start_i && !clear_i;
  assign dec_o  = byte_i && !clear_i && (start_i || state_q == ST_COUNT);
  assign hold_o = (state_q == ST_HOLD);
endmodule

// File: rtl/rrc_counter.sv
module rrc_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic             dec_i,
  input  logic [CNT_W-1:0] size_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, base;
  logic             ovf_q, ovf_d, ovf_base;

  always_comb begin
    base     = load_i ? size_i : cnt_q;
    ovf_base = load_i ? 1'b0   : ovf_q;
    cnt_d    = base;
    ovf_d    = ovf_base;
    if (clear_i) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (dec_i) begin
      if (base == '0) ovf_d = 1'b1;           // saturate, flag surplus byte
      else            cnt_d = base - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/rrc_regs.sv
module rrc_regs #(
  parameter int CNT_W   = 12,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 3,
  parameter int LO_ADDR = 4,
  parameter int HI_ADDR = 5
) (
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int HI_W  = CNT_W - DATA_W;
  localparam int PAD_W = DATA_W - HI_W;

  logic [DATA_W-1:0] lo_byte, hi_byte;

  assign lo_byte = cnt_i[DATA_W-1:0];
  assign hi_byte = {{PAD_W{1'b0}}, cnt_i[CNT_W-1 -: HI_W]};

  always_comb begin
    if (addr_i == ADDR_W'(LO_ADDR))      rdata_o = lo_byte;
    else if (addr_i == ADDR_W'(HI_ADDR)) rdata_o = hi_byte;
    else                                 rdata_o = '0;
  end
endmodule

// File: rtl/rx_remain_counter.sv
module rx_remain_counter #(
  parameter int CNT_W   = 12,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 3,
  parameter int LO_ADDR = 4,
  parameter int HI_ADDR = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_rst_i,
  input  logic              error_rst_i,
  input  logic [CNT_W-1:0]  rx_size_i,
  input  logic              msg_start_i,
  input  logic              byte_strobe_i,
  input  logic              msg_end_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              overflow_o
);
  logic clear, load, dec, hold;
  logic [CNT_W-1:0] cnt;

  assign clear = master_rst_i || error_rst_i;

  rrc_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear),
    .start_i(msg_start_i),
    .byte_i (byte_strobe_i),
    .end_i  (msg_end_i),
    .load_o (load),
    .dec_o  (dec),
    .hold_o (hold)
  );

  rrc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear),
    .load_i (load),
    .dec_i  (dec),
    .size_i (rx_size_i),
    .cnt_o  (cnt),
    .ovf_o  (overflow_o)
  );

  rrc_regs #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
  ) u_regs (
    .cnt_i  (cnt),
    .addr_i (reg_addr_i),
    .rdata_o(reg_rdata_o)
  );
endmodule

// File: rtl/rrc_checker.sv
module rrc_checker #(
  parameter int CNT_W   = 12,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 3,
  parameter int HI_ADDR = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              master_rst_i,
  input logic              error_rst_i,
  input logic [CNT_W-1:0]  rx_size_i,
  input logic              msg_start_i,
  input logic              byte_strobe_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              overflow_o,
  input logic [CNT_W-1:0]  cnt,
  input logic              hold
);
  logic clr;
  assign clr = master_rst_i || error_rst_i;

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (cnt == '0 && !overflow_o));

  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_start_i && !byte_strobe_i && !clr) |=> (cnt == $past(rx_size_i) && !overflow_o));

  a_r6_start_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_start_i && byte_strobe_i && !clr && rx_size_i != '0)
      |=> (cnt == $past(rx_size_i) - CNT_W'(1)));

  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!msg_start_i && !clr) |=> (cnt == $past(cnt) || cnt == $past(cnt) - CNT_W'(1)));

  a_r4_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0 && !msg_start_i && !clr) |=> (cnt == '0));

  a_r4_ovf_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> (cnt == '0));

  a_r5_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold && !msg_start_i && !clr) |=> $stable(cnt));

  a_r7_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_W'(HI_ADDR)) |-> (reg_rdata_o[DATA_W-1:CNT_W-DATA_W] == '0));
endmodule

bind rx_remain_counter rrc_checker #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .HI_ADDR(HI_ADDR)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .master_rst_i (master_rst_i),
  .error_rst_i  (error_rst_i),
  .rx_size_i    (rx_size_i),
  .msg_start_i  (msg_start_i),
  .byte_strobe_i(byte_strobe_i),
  .reg_addr_i   (reg_addr_i),
  .reg_rdata_o  (reg_rdata_o),
  .overflow_o   (overflow_o),
  .cnt          (cnt),
  .hold         (hold)
);

// File: tb/tb_rx_remain_counter.sv
module tb_rx_remain_counter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        master_rst_i = 1'b0;
  logic        error_rst_i = 1'b0;
  logic [11:0] rx_size_i = '0;
  logic        msg_start_i = 1'b0;
  logic        byte_strobe_i = 1'b0;
  logic        msg_end_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        overflow_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  rx_remain_counter dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive one cycle of strobes at negedge, return at next negedge
  task automatic step(input bit st, input bit by, input bit en,
                      input bit mr = 1'b0, input bit er = 1'b0);
    @(negedge clk_i);
    msg_start_i = st; byte_strobe_i = by; msg_end_i = en;
    master_rst_i = mr; error_rst_i = er;
    @(negedge clk_i);
    msg_start_i = 0; byte_strobe_i = 0; msg_end_i = 0;
    master_rst_i = 0; error_rst_i = 0;
  endtask

  task automatic read_count(output logic [11:0] val);
    logic [7:0] lo, hi;
    reg_addr_i = 3'd4; #1 lo = reg_rdata_o;
    reg_addr_i = 3'd5; #1 hi = reg_rdata_o;
    val = {hi[3:0], lo};
  endtask

  task automatic expect_cnt(input string req, input logic [11:0] exp);
    logic [11:0] v;
    read_count(v);
    check(v == exp, req, v, exp);
  endtask

  task automatic t_reset;
    logic [11:0] v;
    read_count(v);
    check(v == 0, "R1 reset count", v, 0);
    check(overflow_o == 0, "R1 reset overflow", overflow_o, 0);
    step(0, 1, 0);
    expect_cnt("R1 idle byte ignored", 12'h000);
    check(overflow_o == 0, "R1 idle no overflow", overflow_o, 0);
  endtask

  task automatic t_load_dec;
    rx_size_i = 12'h5A3;
    step(1, 0, 0);
    expect_cnt("R2 load", 12'h5A3);
    step(0, 1, 0);
    step(0, 1, 0);
    step(0, 1, 0);
    expect_cnt("R3 three bytes", 12'h5A0);
    step(0, 1, 0);
    expect_cnt("R3 borrow across nibble", 12'h59F);
  endtask

  task automatic t_saturate;
    rx_size_i = 12'h002;
    step(1, 0, 0);
    step(0, 1, 0);
    step(0, 1, 0);
    check(overflow_o == 0, "R4 exact fill no overflow", overflow_o, 0);
    step(0, 1, 0);
    expect_cnt("R4 saturate at zero", 12'h000);
    check(overflow_o == 1, "R4 overflow set", overflow_o, 1);
    step(0, 1, 0);
    expect_cnt("R4 no wrap", 12'h000);
    rx_size_i = 12'h010;
    step(1, 0, 0);
    check(overflow_o == 0, "R2 start clears overflow", overflow_o, 0);
  endtask

  task automatic t_end;
    rx_size_i = 12'h100;
    step(1, 0, 0);
    step(0, 1, 0);
    step(0, 1, 1);
    expect_cnt("R5 byte with end counted", 12'h0FE);
    step(0, 1, 0);
    step(0, 1, 0);
    expect_cnt("R5 frozen after end", 12'h0FE);
    rx_size_i = 12'h020;
    step(1, 0, 0);
    step(0, 1, 0);
    expect_cnt("R5 reopened by start", 12'h01F);
  endtask

  task automatic t_start_byte;
    rx_size_i = 12'h7FF;
    step(1, 1, 0);
    expect_cnt("R6 start+byte", 12'h7FE);
    rx_size_i = 12'h000;
    step(1, 1, 0);
    expect_cnt("R6 start+byte size zero", 12'h000);
    check(overflow_o == 1, "R6 size zero overflow", overflow_o, 1);
  endtask

  task automatic t_readback;
    rx_size_i = 12'hABC;
    step(1, 0, 0);
    reg_addr_i = 3'd4; #1;
    check(reg_rdata_o == 8'hBC, "R7 low byte", reg_rdata_o, 8'hBC);
    reg_addr_i = 3'd5; #1;
    check(reg_rdata_o == 8'h0A, "R7 high nibble, reserved zero", reg_rdata_o, 8'h0A);
    for (int a = 0; a < 8; a++) begin
      if (a != 4 && a != 5) begin
        reg_addr_i = 3'(a); #1;
        check(reg_rdata_o == 8'h00, "R7 other offset", reg_rdata_o, 0);
      end
    end
  endtask

  task automatic t_clears;
    rx_size_i = 12'h300;
    step(1, 0, 0);
    step(0, 1, 0, 1, 0);
    expect_cnt("R8 master clear", 12'h000);
    step(0, 1, 0);
    expect_cnt("R8 idle after clear", 12'h000);
    rx_size_i = 12'h001;
    step(1, 0, 0);
    step(0, 1, 0);
    step(0, 1, 0);
    check(overflow_o == 1, "R8 setup overflow", overflow_o, 1);
    step(1, 1, 0, 0, 1);
    expect_cnt("R8 error clear beats start", 12'h000);
    check(overflow_o == 0, "R8 error clear overflow", overflow_o, 0);
  endtask

  task automatic t_full;
    logic [11:0] v;
    rx_size_i = 12'h800;
    step(1, 0, 0);
    @(negedge clk_i);
    byte_strobe_i = 1;
    repeat (2048) @(negedge clk_i);
    byte_strobe_i = 0;
    step(0, 0, 1);
    read_count(v);
    check(v == 0, "R9 full residual", v, 0);
    check(overflow_o == 0, "R9 full no overflow", overflow_o, 0);
    check(int'(rx_size_i) - int'(v) == 2048, "R9 length", int'(rx_size_i) - int'(v), 2048);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_load_dec();
    t_saturate();
    t_end();
    t_start_byte();
    t_readback();
    t_clears();
    t_full();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule